// File: doc/BRIEF.md
# Masked Operand Computation Unit

This unit sits between a register file and a 16-bit ALU and carries one operation at a time. On issue it captures the operation and its side flags. It then asks for each of its two source operands through a separate read handshake: it raises a read release and waits for the matching read go. Once every operand port is satisfied, it hands the operands to the ALU over a valid/ready link. When the ALU returns a result, the unit latches it and asks for the register-file write through a write release and write go pair.

Any operand read can be skipped, so an operation may finish without touching every port. There are four ways to skip a read:
- a per-port read-mask bit;
- a zero-A flag, which forces operand A to zero;
- an immediate-valid flag, which replaces operand B with the issued immediate;
- the no-operation code.

A no-operation also raises a write-skip output, so the scheduler knows that no write will follow.

The release/go pairs are level handshakes. A release stays high until its go is seen on a rising edge, and a go with no pending release is ignored. The internal ALU link moves data only in a cycle where valid and ready are both high. The ALU holds its output stable while ready is low.

Top module: `masked_opcu`

## Requirements
- R1: The operation codes on `op_i` are: 0 no-op, 1 add, 2 subtract (A−B), 3 bitwise and, 4 bitwise xor, 5 sign-extend the low 8 bits of A. Codes 6 and 7 give zero. When `inv_i` is set, operand A is bit-inverted after masking or forcing and before the operation. All arithmetic wraps at 16 bits.
- R2: After issue, each read port that is not skipped raises its bit of `rd_req_o` (bit 0 for A, bit 1 for B). The bit stays high until that port's `rd_go_i` bit is sampled high on a clock edge, and it is low in the next cycle. The port's source data is captured on that edge.
- R3: A port whose `rd_mask_i` bit is high never raises its release, and it counts as satisfied. Its operand enters the ALU as zero. A read go on such a port is ignored.
- R4: `rd_mask_i` is not captured at issue. It acts live for as long as busy is high, so setting a mask bit while a release is pending drops that release and makes the operand zero.
- R5: When the zero-A flag is latched and port 0 is not masked, operand A is zero and port 0 makes no read request.
- R6: When the immediate-valid flag is latched and port 1 is not masked, operand B is the latched immediate and port 1 makes no read request.
- R7: For a no-op, the unit makes no read requests and never raises `wr_req_o`. It holds `wr_skip_o` high while busy. For any other code, `wr_skip_o` stays low.
- R8: The operation code, invert flag, immediate, immediate-valid flag and zero-A flag are sampled only on the edge that accepts an issue. Later changes to these inputs have no effect on the operation in flight.
- R9: Read go responses may arrive after independent delays on each port, and write go after any delay. The result does not depend on these delays.
- R10: `wr_req_o` rises with `res_o` holding the result and stays high, with `res_o` stable, until `wr_go_i` is sampled high.
- R11: `busy_o` is high from the cycle after an accepted issue. It goes low in the cycle after `wr_go_i` is sampled with `wr_req_o` high, or, for a no-op, in the cycle after the ALU result is taken. An `issue_i` while busy is ignored.
- R12: After reset, `busy_o`, `rd_req_o`, `wr_req_o` and `wr_skip_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue strobe, taken only while not busy |
| op_i | input | 3 | Operation code |
| inv_i | input | 1 | Invert operand A |
| imm_i | input | 16 | Immediate value for operand B |
| imm_ok_i | input | 1 | Immediate valid: skip read of port 1 |
| zero_a_i | input | 1 | Force operand A to zero: skip read of port 0 |
| busy_o | output | 1 | Operation in flight |
| rd_mask_i | input | 2 | Live per-port read mask, active high |
| rd_req_o | output | 2 | Per-port read release |
| rd_go_i | input | 2 | Per-port read go |
| src_a_i | input | 16 | Operand data for port 0 |
| src_b_i | input | 16 | Operand data for port 1 |
| wr_req_o | output | 1 | Write release |
| wr_go_i | input | 1 | Write go |
| wr_skip_o | output | 1 | No write will be made for this operation |
| res_o | output | 16 | Result data |

## Verification
The main sweep runs every operation code against every read-mask value and every combination of the zero-A and immediate flags. Read and write go delays vary across the sweep, and go is driven continuously with poisoned data on every port that should stay quiet. This separates the four reasons a read can be skipped and shows that mask takes priority over forcing. Ignored go pulses and delay-independent results show up as wrong arithmetic. Targeted cases change the mask while a release is pending, pulse issue and scramble the issue fields in the middle of an operation, and use operands with bit 7 set to tell sign-extension apart from zero-extension.

// File: rtl/opcu_pkg.sv
package opcu_pkg;
  localparam int unsigned OPW = 3;

  localparam logic [OPW-1:0] OP_NOP  = 3'd0;
  localparam logic [OPW-1:0] OP_ADD  = 3'd1;
  localparam logic [OPW-1:0] OP_SUB  = 3'd2;
  localparam logic [OPW-1:0] OP_AND  = 3'd3;
  localparam logic [OPW-1:0] OP_XOR  = 3'd4;
  localparam logic [OPW-1:0] OP_SEXT = 3'd5;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_READ  = 2'd1,
    S_RES   = 2'd2,
    S_WRITE = 2'd3
  } cu_state_e;
endpackage

// File: rtl/opcu_rd_port.sv
module opcu_rd_port #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          active,
  input  logic          skip,
  input  logic          go,
  input  logic [DW-1:0] din,
  output logic          req,
  output logic          done,
  output logic [DW-1:0] dq
);
  logic          pend_q;
  logic [DW-1:0] data_q;

  assign req  = active & pend_q & ~skip;
  assign done = ~pend_q | skip;
  assign dq   = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (start) begin
      pend_q <= 1'b1;
      data_q <= '0;
    end else if (go && req) begin
      pend_q <= 1'b0;
      data_q <= din;
    end
  end

  // R2: release is gone the cycle after its go is taken
  a_r2_rel_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (go && req) |=> !req);

  // R9: a pending read waits as long as no go arrives
  a_r9_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !go && !start) |=> pend_q);
endmodule

// File: rtl/opcu_alu.sv
module opcu_alu
  import opcu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] op,
  input  logic           inv,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data
);
  localparam int unsigned HB = DW / 2;

  logic          ov_q;
  logic [DW-1:0] od_q;
  logic [DW-1:0] a2;
  logic [DW-1:0] f;

  assign a2 = inv ? ~a : a;

  always_comb begin
    case (op)
      OP_ADD:  f = a2 + b;
      OP_SUB:  f = a2 - b;
      OP_AND:  f = a2 & b;
      OP_XOR:  f = a2 ^ b;
      OP_SEXT: f = {{(DW-HB){a2[HB-1]}}, a2[HB-1:0]};
      default: f = '0;
    endcase
  end

  assign in_ready  = ~ov_q | out_ready;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (in_valid && in_ready) begin
      ov_q <= 1'b1;
      od_q <= f;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  // R10: a stalled result is held
  a_r10_alu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/masked_opcu.sv
module masked_opcu
  import opcu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_i,
  input  logic [2:0]     op_i,
  input  logic           inv_i,
  input  logic [DW-1:0]  imm_i,
  input  logic           imm_ok_i,
  input  logic           zero_a_i,
  output logic           busy_o,
  input  logic [1:0]     rd_mask_i,
  output logic [1:0]     rd_req_o,
  input  logic [1:0]     rd_go_i,
  input  logic [DW-1:0]  src_a_i,
  input  logic [DW-1:0]  src_b_i,
  output logic           wr_req_o,
  input  logic           wr_go_i,
  output logic           wr_skip_o,
  output logic [DW-1:0]  res_o
);
  localparam int unsigned NRD = 2;

  cu_state_e      state_q;
  logic [OPW-1:0] op_q;
  logic           inv_q, imm_ok_q, zero_a_q;
  logic [DW-1:0]  imm_q, res_q;

  logic                    start, nop_q, all_done;
  logic [NRD-1:0]          forced, skip, done;
  logic [NRD-1:0][DW-1:0]  src_in, dq;
  logic [DW-1:0]           opa, opb, alu_out;
  logic                    alu_iv, alu_ir, alu_ov, alu_or;

  assign start    = (state_q == S_IDLE) && issue_i;
  assign nop_q    = (op_q == OP_NOP);
  assign forced   = {nop_q | imm_ok_q, nop_q | zero_a_q};
  assign skip     = rd_mask_i | forced;
  assign src_in   = {src_b_i, src_a_i};
  assign all_done = &done;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    opcu_rd_port #(.DW(DW)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .active (state_q == S_READ),
      .skip   (skip[p]),
      .go     (rd_go_i[p]),
      .din    (src_in[p]),
      .req    (rd_req_o[p]),
      .done   (done[p]),
      .dq     (dq[p])
    );

    // R3: a masked port never raises its release
    a_r3_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mask_i[p] |-> !rd_req_o[p]);
  end

  assign opa = skip[0] ? '0 : dq[0];
  assign opb = rd_mask_i[1] ? '0 : (imm_ok_q ? imm_q : (nop_q ? '0 : dq[1]));

  assign alu_iv = (state_q == S_READ) && all_done;
  assign alu_or = (state_q == S_RES);

  opcu_alu #(.DW(DW)) u_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (alu_iv),
    .in_ready  (alu_ir),
    .op        (op_q),
    .inv       (inv_q),
    .a         (opa),
    .b         (opb),
    .out_valid (alu_ov),
    .out_ready (alu_or),
    .out_data  (alu_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= OP_NOP;
      inv_q    <= 1'b0;
      imm_q    <= '0;
      imm_ok_q <= 1'b0;
      zero_a_q <= 1'b0;
      res_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (issue_i) begin
          op_q     <= op_i;
          inv_q    <= inv_i;
          imm_q    <= imm_i;
          imm_ok_q <= imm_ok_i;
          zero_a_q <= zero_a_i;
          state_q  <= S_READ;
        end
        S_READ: if (alu_iv && alu_ir) state_q <= S_RES;
        S_RES: if (alu_ov) begin
          res_q   <= alu_out;
          state_q <= nop_q ? S_IDLE : S_WRITE;
        end
        S_WRITE: if (wr_go_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign wr_req_o  = (state_q == S_WRITE);
  assign wr_skip_o = busy_o && nop_q;
  assign res_o     = res_q;

  // R7: a skipped write never raises the write release
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_skip_o |-> !wr_req_o);

  // R10: write release and result hold until write go
  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_go_i) |=> (wr_req_o && $stable(res_o)));

  // R11: busy ends the cycle after the write go
  a_r11_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_go_i) |=> !busy_o);

  // R8: the latched operation does not change while busy
  a_r8_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!busy_o || $stable(op_q)));
endmodule

// File: tb/sim_masked_opcu.sv
`timescale 1ns/1ps
module sim_masked_opcu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        inv_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic        imm_ok_i = 1'b0;
  logic        zero_a_i = 1'b0;
  logic        busy_o;
  logic [1:0]  rd_mask_i = '0;
  logic [1:0]  rd_req_o;
  logic [1:0]  rd_go_i = '0;
  logic [15:0] src_a_i = '0;
  logic [15:0] src_b_i = '0;
  logic        wr_req_o;
  logic        wr_go_i = 1'b0;
  logic        wr_skip_o;
  logic [15:0] res_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  masked_opcu #(.DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .inv_i(inv_i),
    .imm_i(imm_i), .imm_ok_i(imm_ok_i), .zero_a_i(zero_a_i), .busy_o(busy_o),
    .rd_mask_i(rd_mask_i), .rd_req_o(rd_req_o), .rd_go_i(rd_go_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .wr_req_o(wr_req_o),
    .wr_go_i(wr_go_i), .wr_skip_o(wr_skip_o), .res_o(res_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [2:0] op, input bit inv,
                                        input logic [15:0] a, input logic [15:0] b);
    logic [15:0] a2;
    a2 = inv ? ~a : a;
    case (op)
      3'd1: return a2 + b;
      3'd2: return a2 - b;
      3'd3: return a2 & b;
      3'd4: return a2 ^ b;
      3'd5: return {{8{a2[7]}}, a2[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input bit inv, input logic [15:0] a,
                     input logic [15:0] b, input logic [15:0] imm, input bit io,
                     input bit za, input logic [1:0] m, input int da, input int db,
                     input int dw, input bit late_mask, input bit poke);
    bit nop, r0, r1, m0, wseen, wgo, skip_seen, skip_bad, done, rel_bad;
    logic [15:0] ea, eb, exp, res_first;
    int cnt [2];
    int dly [2];
    bit go_on [2];
    bit seen [2];
    bit rexp [2];
    nop = (op == 3'd0);
    m0 = m[0] | late_mask;
    r0 = !nop && !m[0] && !za;
    r1 = !nop && !m[1] && !io;
    ea = (m0 || za || nop) ? 16'h0 : a;
    eb = m[1] ? 16'h0 : (io ? imm : (nop ? 16'h0 : b));
    exp = model(op, inv, ea, eb);
    dly[0] = da; dly[1] = db;
    rexp[0] = r0; rexp[1] = r1;
    for (int p = 0; p < 2; p++) begin cnt[p] = 0; go_on[p] = 0; seen[p] = 0; end
    wseen = 0; wgo = 0; skip_seen = 0; skip_bad = 0; done = 0; rel_bad = 0;
    res_first = '0;

    @(negedge clk);
    issue_i = 1'b1; op_i = op; inv_i = inv; imm_i = imm; imm_ok_i = io; zero_a_i = za;
    rd_mask_i = m;
    src_a_i = r0 ? a : 16'hDEAD;
    src_b_i = r1 ? b : 16'hBEEF;
    rd_go_i = {~r1, ~r0};
    @(negedge clk);
    issue_i = 1'b0; op_i = ~op; inv_i = ~inv; imm_i = ~imm; imm_ok_i = ~io; zero_a_i = ~za;
    chk(busy_o == 1'b1, "R11 busy after issue", {15'h0, busy_o}, 16'h1);

    for (int it = 0; it < 80 && !done; it++) begin
      if (poke && it == 2) begin
        issue_i = 1'b1; op_i = 3'd1;
      end else if (poke && it == 3) begin
        issue_i = 1'b0;
      end
      for (int p = 0; p < 2; p++) begin
        if (late_mask && p == 0 && it > 0) begin
          if (rd_req_o[0]) rel_bad = 1;
        end else if (go_on[p]) begin
          chk(rd_req_o[p] == 1'b0, "R2 release drops after go", {15'h0, rd_req_o[p]}, 16'h0);
          go_on[p] = 0;
          rd_go_i[p] = 1'b0;
        end else if (rd_req_o[p]) begin
          seen[p] = 1;
          if (late_mask && p == 0) begin
            rd_mask_i[0] = 1'b1;
            rd_go_i[0] = 1'b1;
            src_a_i = 16'hDEAD;
          end else if (cnt[p] >= dly[p]) begin
            rd_go_i[p] = 1'b1;
            go_on[p] = 1;
          end else cnt[p]++;
        end
      end
      if (nop) begin
        if (busy_o && wr_skip_o) skip_seen = 1;
        if (wr_req_o) wseen = 1;
        if (!busy_o) done = 1;
      end else begin
        if (wr_skip_o) skip_bad = 1;
        if (wgo) begin
          chk(busy_o == 1'b0 && wr_req_o == 1'b0, "R11 busy drops after write go",
              {14'h0, busy_o, wr_req_o}, 16'h0);
          wr_go_i = 1'b0;
          done = 1;
        end else if (wr_req_o) begin
          if (!wseen) begin
            res_first = res_o;
            chk(res_o == exp, $sformatf("R1 R9 result op=%0d m=%0d za=%0d io=%0d", op, m, za, io),
                res_o, exp);
            wseen = 1;
          end else if (res_o != res_first) rel_bad = 1;
          if (cnt[0] >= 0 && dw <= 0) begin
            wr_go_i = 1'b1; wgo = 1;
          end else dw--;
        end
      end
      @(negedge clk);
    end

    chk(done, "R9 operation completes", {15'h0, done}, 16'h1);
    for (int p = 0; p < 2; p++)
      chk(seen[p] == rexp[p], $sformatf("R3 R5 R6 read request port %0d", p),
          {15'h0, seen[p]}, {15'h0, rexp[p]});
    chk(!rel_bad, "R4 R10 release and result held", {15'h0, rel_bad}, 16'h0);
    if (nop) begin
      chk(skip_seen && !wseen, "R7 no-op skips write", {14'h0, skip_seen, wseen}, 16'h2);
    end else begin
      chk(!skip_bad, "R7 write-skip low for real op", {15'h0, skip_bad}, 16'h0);
    end
    rd_go_i = '0; rd_mask_i = '0; wr_go_i = 1'b0; issue_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy_o == 0 && rd_req_o == 0 && wr_req_o == 0 && wr_skip_o == 0,
        "R12 reset outputs", {12'h0, busy_o, rd_req_o[0], wr_req_o, wr_skip_o}, 16'h0);

    k = 0;
    for (int op = 0; op < 6; op++)
      for (int m = 0; m < 4; m++)
        for (int za = 0; za < 2; za++)
          for (int io = 0; io < 2; io++) begin
            run(3'(op), 1'((op + m) % 2), 16'h1234 ^ 16'(k * 16'h0931),
                16'h0F0F + 16'(k * 16'h0107), 16'h00A5 + 16'(k), 1'(io), 1'(za),
                2'(m), k % 4, (k / 2) % 3, k % 3, 1'b0, 1'b0);
            k++;
          end
    // R1 sign extension with bit 7 set, and unused code
    run(3'd5, 1'b0, 16'h0080, 16'h0002, 16'h0, 1'b0, 1'b0, 2'b00, 2, 1, 0, 1'b0, 1'b0);
    run(3'd5, 1'b1, 16'h0080, 16'h0002, 16'h0, 1'b0, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0);
    run(3'd7, 1'b0, 16'h1111, 16'h2222, 16'h0, 1'b0, 1'b0, 2'b00, 1, 1, 1, 1'b0, 1'b0);
    // R1 wrap of add and subtract
    run(3'd1, 1'b0, 16'hFFFF, 16'h0003, 16'h0, 1'b0, 1'b0, 2'b00, 1, 4, 2, 1'b0, 1'b0);
    run(3'd2, 1'b0, 16'h0001, 16'h0003, 16'h0, 1'b0, 1'b0, 2'b00, 5, 0, 6, 1'b0, 1'b0);
    // R4 mask raised while port 0 release is pending
    run(3'd1, 1'b0, 16'h4321, 16'h0010, 16'h0, 1'b0, 1'b0, 2'b00, 3, 2, 1, 1'b1, 1'b0);
    // R8 R11 issue pulse and scrambled fields mid-operation
    run(3'd4, 1'b1, 16'h5A5A, 16'h00FF, 16'h0, 1'b0, 1'b0, 2'b00, 4, 6, 5, 1'b0, 1'b1);
    run(3'd2, 1'b0, 16'h0100, 16'h0000, 16'h0040, 1'b1, 1'b0, 2'b00, 3, 0, 4, 1'b0, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule